// File: doc/BRIEF.md
# Privileged Processor Status Register

This block holds the 32-bit status word of a processor core. Software changes it through a write port with a per-bit enable mask and reads it back at any time. Hardware changes it on reset and whenever an exception or interrupt is taken. Entering an exception or interrupt forces the core into privileged mode, selects the alternate register bank, and raises the block flag, which then holds off further interrupts.

The block exports the privilege level, the bank select, the block flag and the 4-bit interrupt mask level to the rest of the core. It also decides whether a pending interrupt at a given priority may be accepted.

A general exception that arrives while the block flag is already set cannot be taken safely. The block then holds its state and issues a one-cycle reset request instead. A user-break exception is the one kind that is still taken normally in that case.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset, rd_data reads 0x7000_00F0: privilege (bit 30) = 1, bank select (bit 29) = 1, block (bit 28) = 1, mask (bits 7:4) = 4'hF, and every other bit 0.
- R2: Only bits 30, 29, 28, 15, 9, 8, 7:4, 1 and 0 are implemented (mask 0x7000_83F3). Every other bit reads 0, and writing 1 to it leaves it at 0.
- R3: When wr_en is high, each implemented bit whose wr_mask bit is 1 takes wr_data in the next cycle, and bits whose wr_mask bit is 0 keep their value. With no write and no event, the word does not change.
- R4: An interrupt entry (irq_evt) or a taken exception (exc_evt) sets bits 30, 29 and 28 to 1 in the next cycle and leaves every other bit unchanged.
- R5: A write and an entry event in the same cycle resolve as follows: bits 30:28 become 1, and every other bit follows the masked write.
- R6: irq_accept is high exactly when irq_req is 1, the block bit is 0, and irq_lvl is strictly greater than the mask field.
- R7: exc_evt with exc_is_ubrk = 0 while the block bit is 1 raises rst_req in the next cycle for one cycle. In that cycle the register keeps its value, and any write or event presented with it is dropped.
- R8: exc_evt with exc_is_ubrk = 1 while the block bit is 1 is taken like a normal exception (R4) and raises no rst_req.
- R9: priv_mode, bank_sel, blk and imask always equal bits 30, 29, 28 and 7:4 of rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_mask | input | 32 | Per-bit write enable |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current status word |
| exc_evt | input | 1 | General exception entry pulse |
| exc_is_ubrk | input | 1 | Qualifies exc_evt as a user-break exception |
| irq_evt | input | 1 | Interrupt entry pulse |
| irq_req | input | 1 | An interrupt request is pending |
| irq_lvl | input | 4 | Priority of the pending request |
| irq_accept | output | 1 | Pending request may be taken |
| priv_mode | output | 1 | 1 = privileged, 0 = user |
| bank_sel | output | 1 | Register bank select |
| blk | output | 1 | Exception/interrupt block flag |
| imask | output | 4 | Interrupt mask level |
| rst_req | output | 1 | Escalation reset request pulse |

## Verification
Writes are tried with full, partial and reserved-only masks. These show masked-out bits holding and unimplemented bits staying at zero. Entry events are applied alone and together with a write that clears every bit, which separates the forced bits from the bits that follow the write. Exceptions arrive both with the block flag clear and with it set, and with and without the user-break qualifier, so taken entries can be told apart from escalations. Interrupt acceptance is probed at a level equal to the mask, one above it, and with the block flag set.

// File: rtl/cpu_status_reg.sv
`timescale 1ns/1ps
module cpu_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         exc_evt,
  input  logic         exc_is_ubrk,
  input  logic         irq_evt,
  input  logic         irq_req,
  input  logic [3:0]   irq_lvl,
  output logic         irq_accept,
  output logic         priv_mode,
  output logic         bank_sel,
  output logic         blk,
  output logic [3:0]   imask,
  output logic         rst_req
);
  localparam int PRIV_B = 30;
  localparam int BANK_B = 29;
  localparam int BLK_B  = 28;
  localparam int MASK_LO = 4;
  localparam logic [W-1:0] IMPL  = W'(32'h7000_83F3);
  localparam logic [W-1:0] RSTV  = W'(32'h7000_00F0);
  localparam logic [W-1:0] FORCE = (W'(1) << PRIV_B) | (W'(1) << BANK_B) | (W'(1) << BLK_B);

  logic [W-1:0] word_q, written, next_word;
  logic         escalate, entry;

  assign escalate = exc_evt && word_q[BLK_B] && !exc_is_ubrk;
  assign entry    = irq_evt || exc_evt;
  assign written  = wr_en ? ((word_q & ~wr_mask) | (wr_data & wr_mask)) : word_q;

  always_comb begin
    next_word = written & IMPL;
    if (entry) next_word = next_word | FORCE;
    if (escalate) next_word = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= RSTV;
      rst_req <= 1'b0;
    end else begin
      word_q  <= next_word;
      rst_req <= escalate;
    end
  end

  assign rd_data    = word_q;
  assign priv_mode  = word_q[PRIV_B];
  assign bank_sel   = word_q[BANK_B];
  assign blk        = word_q[BLK_B];
  assign imask      = word_q[MASK_LO +: 4];
  assign irq_accept = irq_req && !blk && (irq_lvl > imask);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL) == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !exc_evt && !irq_evt) |=> $stable(rd_data));

  p_entry_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt || (exc_evt && (!rd_data[BLK_B] || exc_is_ubrk))) |=> (rd_data[30:28] == 3'b111));

  p_accept_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> (!blk && irq_req && (irq_lvl > imask)));

  p_escalate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && rd_data[BLK_B] && !exc_is_ubrk) |=> (rst_req && $stable(rd_data)));

  p_rstreq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(exc_evt && blk && !exc_is_ubrk));

  p_ubrk_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && exc_is_ubrk) |=> !rst_req);
endmodule

// File: tb/test_cpu_status_reg.sv
`timescale 1ns/1ps
module test_cpu_status_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, exc_evt = 0, exc_is_ubrk = 0, irq_evt = 0, irq_req = 0;
  logic [31:0] wr_mask = '0, wr_data = '0;
  logic [3:0] irq_lvl = '0;
  logic [31:0] rd_data;
  logic irq_accept, priv_mode, bank_sel, blk, rst_req;
  logic [3:0] imask;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_status_reg i_cpu_status_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_data(rd_data), .exc_evt(exc_evt), .exc_is_ubrk(exc_is_ubrk), .irq_evt(irq_evt),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_accept(irq_accept), .priv_mode(priv_mode),
    .bank_sel(bank_sel), .blk(blk), .imask(imask), .rst_req(rst_req));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] m, input logic [31:0] d);
    wr_en = 1; wr_mask = m; wr_data = d; step(); wr_en = 0; wr_mask = '0; wr_data = '0;
  endtask

  task automatic t_reset();
    check("R1 reset word", rd_data, 32'h7000_00F0);
    check("R9 outputs", {priv_mode, bank_sel, blk, imask, rst_req}, {1'b1, 1'b1, 1'b1, 4'hF, 1'b0});
  endtask

  task automatic t_write();
    wr(32'h0000_0F00, 32'hFFFF_FFFF);
    check("R3 partial mask", rd_data, 32'h7000_03F0);
    wr(32'hFFFF_FFFF, 32'h0000_0003);
    check("R3 full mask", rd_data, 32'h0000_0003);
    check("R9 outputs follow", {priv_mode, bank_sel, blk, imask}, 7'b0);
    step();
    check("R3 hold", rd_data, 32'h0000_0003);
  endtask

  task automatic t_rsvd();
    wr(32'h8FFF_7C0C, 32'hFFFF_FFFF);
    check("R2 reserved write", rd_data, 32'h0000_0003);
  endtask

  task automatic t_entry();
    irq_evt = 1; step(); irq_evt = 0;
    check("R4 irq entry", rd_data, 32'h7000_0003);
    wr(32'h7000_0000, 32'h0);
    exc_evt = 1; step(); exc_evt = 0;
    check("R4 exception entry", rd_data, 32'h7000_0003);
    check("R7 no escalation when unblocked", {31'b0, rst_req}, 32'h0);
  endtask

  task automatic t_same_cycle();
    wr(32'hFFFF_FFFF, 32'h0000_8001);
    wr_en = 1; wr_mask = 32'hFFFF_FFFF; wr_data = 32'h0000_0100; irq_evt = 1;
    step();
    wr_en = 0; irq_evt = 0; wr_mask = '0; wr_data = '0;
    check("R5 write with event", rd_data, 32'h7000_0100);
  endtask

  task automatic t_accept();
    wr(32'hFFFF_FFFF, 32'h0000_0050);
    irq_req = 1; irq_lvl = 4'd5; #1;
    check("R6 level equal mask", {31'b0, irq_accept}, 32'h0);
    irq_lvl = 4'd6; #1;
    check("R6 level above mask", {31'b0, irq_accept}, 32'h1);
    irq_req = 0; #1;
    check("R6 no request", {31'b0, irq_accept}, 32'h0);
    wr(32'h1000_0000, 32'h1000_0000);
    irq_req = 1; irq_lvl = 4'hF; #1;
    check("R6 blocked", {31'b0, irq_accept}, 32'h0);
    irq_req = 0;
  endtask

  task automatic t_escalate();
    exc_evt = 1; exc_is_ubrk = 0;
    wr_en = 1; wr_mask = 32'hFFFF_FFFF; wr_data = 32'h0;
    step();
    exc_evt = 0; wr_en = 0; wr_mask = '0;
    check("R7 reset request", {31'b0, rst_req}, 32'h1);
    check("R7 word held", rd_data, 32'h1000_0050);
    step();
    check("R7 single pulse", {31'b0, rst_req}, 32'h0);
  endtask

  task automatic t_ubrk();
    exc_evt = 1; exc_is_ubrk = 1; step(); exc_evt = 0; exc_is_ubrk = 0;
    check("R8 ubrk taken", rd_data, 32'h7000_0050);
    check("R8 no reset request", {31'b0, rst_req}, 32'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    step();
    t_reset();
    t_write();
    t_rsvd();
    t_entry();
    t_same_cycle();
    t_accept();
    t_escalate();
    t_ubrk();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule